// File: doc/BRIEF.md
# Write-Invalidate Snooping Coherence Cluster

This block keeps two to four small write-back data caches coherent over one shared snooping bus. Each core owns a direct-mapped cache whose lines sit in one of three states: invalid, shared-clean or modified. A core presents loads and stores on its own request port and waits while its busy flag is high. A controller that cannot finish locally asks for the bus, and a round-robin arbiter grants one controller per cycle. Every controller watches each granted transaction. A controller holding the addressed line modified supplies the data in place of memory. Read-for-ownership and invalidate transactions remove all other copies.

A bus transaction takes exactly one cycle. In that cycle the requester updates its line and each snooper updates its own copy. Because only one transaction is on the bus at a time, every core sees writes to any address in the same order. The backing memory sits outside the block. It answers a read address on the same cycle and takes at most one write per cycle, either a victim writeback or a copy of data that a snooper supplied.

Top module: `snoop_cache_cluster`

## Requirements
- R1: After reset every line is invalid, no core is busy, `core_rsp_valid`, `bus_valid` and `mem_wr_en` are low, and the first access of any core causes a bus transaction.
- R2: A load that misses issues a bus read (`bus_cmd` 2'd0) and returns the memory word. A repeated load of that address returns the same word with no bus transaction.
- R3: A store to a line the cache lacks issues a read-for-ownership (`bus_cmd` 2'd1). It leaves memory unchanged, so stores are not written through.
- R4: A store to a line held shared issues an invalidate (`bus_cmd` 2'd2) that carries no data and writes no memory, then holds the line modified.
- R5: A store to a line held modified completes with no bus transaction.
- R6: When another core reads a line held modified, the owner supplies the data and memory takes the same word. The owner keeps a shared copy: its next load hits, and its next store issues an invalidate.
- R7: When another core issues a read-for-ownership on a line held modified, the owner supplies its data, memory takes that word, and the owner's copy becomes invalid.
- R8: After another core invalidates or takes ownership of a line, the next load of that line by a former sharer misses and returns the newest value.
- R9: A miss whose set holds a modified line with a different tag first issues a writeback (`bus_cmd` 2'd3) of the old address and data, then the fetch.
- R10: When several controllers request the bus together, one is granted per cycle in rotating order, starting at the core after the last one granted. `bus_src` names the granted core.
- R11: At most one cache supplies data in any transaction.
- R12: Busy is high from the cycle after a request is presented until the response. `core_rsp_valid` is a one-cycle pulse. The core holds its request fields until that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req_valid | input | NCORES | Per-core request present |
| core_req_write | input | NCORES | Per-core store (1) or load (0) |
| core_req_addr | input | NCORES*AW | Per-core word address, core i at bits [i*AW +: AW] |
| core_req_wdata | input | NCORES*DW | Per-core store data |
| core_busy | output | NCORES | Per-core request in progress |
| core_rsp_valid | output | NCORES | Per-core one-cycle completion pulse |
| core_rsp_rdata | output | NCORES*DW | Per-core load data (store data on stores) |
| bus_valid | output | 1 | A transaction is on the bus this cycle |
| bus_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 invalidate, 3 writeback |
| bus_addr | output | AW | Transaction address |
| bus_src | output | SRCW | Index of the granted core |
| mem_rd_addr | output | AW | Memory read address |
| mem_rd_data | input | DW | Memory read data, same cycle |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | AW | Memory write address |
| mem_wr_data | output | DW | Memory write data |

## Verification
The hardest cases to reach depend on what a remote core has left behind: a line that another cache holds modified, a sharer whose copy must be destroyed, and a modified victim in the same set as a new miss. The stimulus builds each history from the ports with a short chain of loads and stores across cores. For example, it stores from one core, reads from another and stores again, then checks the bus log and the memory model at each step. The arbitration order is tested by releasing requests from all cores on the same falling edge. The expected grant order is computed from the last granted core in the bus log.

// File: rtl/snoopc_pkg.sv
package snoopc_pkg;
   typedef enum logic [1:0] {
      LN_INV = 2'b00,
      LN_SHD = 2'b01,
      LN_MOD = 2'b10
   } line_st_e;

   typedef enum logic [1:0] {
      BC_READ  = 2'd0,
      BC_RDOWN = 2'd1,
      BC_KILL  = 2'd2,
      BC_WBACK = 2'd3
   } bus_op_e;

   typedef enum logic [1:0] {
      CS_IDLE = 2'd0,
      CS_BUS  = 2'd1,
      CS_DONE = 2'd2
   } ctl_st_e;
endpackage

// File: rtl/rr_bus_arbiter.sv
module rr_bus_arbiter #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);
   localparam int PW = (N > 1) ? $clog2(N) : 1;

   logic [PW-1:0] ptr_q;
   logic [PW-1:0] win;

   // lowest rotated offset wins: scan from the far end so the nearest overwrites
   always_comb begin
      gnt = '0;
      win = ptr_q;
      for (int off = N - 1; off >= 0; off--) begin
         int k;
         k = (int'(ptr_q) + off) % N;
         if (req[k]) begin
            gnt    = '0;
            gnt[k] = 1'b1;
            win    = PW'(k);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (|req) begin
         ptr_q <= (int'(win) == N - 1) ? '0 : win + 1'b1;
      end
   end
endmodule

// File: rtl/coh_ctrl.sv
module coh_ctrl
   import snoopc_pkg::*;
#(
   parameter int AW    = 8,
   parameter int DW    = 16,
   parameter int NSETS = 4,
   parameter int SRCW  = 2,
   parameter int MY_ID = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic            req_write,
   input  logic [AW-1:0]   req_addr,
   input  logic [DW-1:0]   req_wdata,
   output logic            busy,
   output logic            rsp_valid,
   output logic [DW-1:0]   rsp_rdata,
   output logic            bus_req,
   input  logic            bus_gnt,
   output logic [1:0]      bus_cmd_o,
   output logic [AW-1:0]   bus_addr_o,
   output logic [DW-1:0]   bus_wdata_o,
   input  logic            bus_valid,
   input  logic [1:0]      bus_cmd,
   input  logic [AW-1:0]   bus_addr,
   input  logic [SRCW-1:0] bus_src,
   input  logic [DW-1:0]   bus_rdata,
   output logic            flush_o,
   output logic [DW-1:0]   flush_data_o
);
   localparam int IW = $clog2(NSETS);
   localparam int TW = AW - IW;

   line_st_e        st_q  [NSETS];
   logic [TW-1:0]   tag_q [NSETS];
   logic [DW-1:0]   dat_q [NSETS];
   ctl_st_e         cs_q;
   logic [DW-1:0]   rsp_q;

   // own lookup
   logic [IW-1:0]   r_idx;
   logic [TW-1:0]   r_tag;
   line_st_e        cur_st;
   logic            match;
   logic            need_wb;
   logic            local_hit;
   bus_op_e         cmd_live;

   assign r_idx  = req_addr[IW-1:0];
   assign r_tag  = req_addr[AW-1:IW];
   assign cur_st = st_q[r_idx];
   assign match  = (cur_st != LN_INV) && (tag_q[r_idx] == r_tag);
   assign need_wb   = (cur_st == LN_MOD) && !match;
   assign local_hit = match && (!req_write || cur_st == LN_MOD);

   always_comb begin
      if (need_wb)                               cmd_live = BC_WBACK;
      else if (!req_write)                       cmd_live = BC_READ;
      else if (match && cur_st == LN_SHD)        cmd_live = BC_KILL;
      else                                       cmd_live = BC_RDOWN;
   end

   assign bus_req     = (cs_q == CS_BUS);
   assign bus_cmd_o   = cmd_live;
   assign bus_addr_o  = need_wb ? {tag_q[r_idx], r_idx} : req_addr;
   assign bus_wdata_o = dat_q[r_idx];

   // snoop side
   logic [IW-1:0] s_idx;
   logic [TW-1:0] s_tag;
   logic          foreign;
   logic          s_hit;
   logic          conflict;

   assign s_idx    = bus_addr[IW-1:0];
   assign s_tag    = bus_addr[AW-1:IW];
   assign foreign  = bus_valid && (bus_src != SRCW'(MY_ID));
   assign s_hit    = foreign && (st_q[s_idx] != LN_INV) && (tag_q[s_idx] == s_tag);
   assign conflict = foreign && (s_idx == r_idx);
   assign flush_o  = s_hit && (st_q[s_idx] == LN_MOD) &&
                     (bus_cmd == BC_READ || bus_cmd == BC_RDOWN);
   assign flush_data_o = dat_q[s_idx];

   logic own_done;
   logic own_wb;
   logic hit_go;
   assign hit_go   = (cs_q == CS_IDLE) && req_valid && !conflict && local_hit;
   assign own_wb   = (cs_q == CS_BUS) && bus_gnt && (cmd_live == BC_WBACK);
   assign own_done = (cs_q == CS_BUS) && bus_gnt && (cmd_live != BC_WBACK);

   // control state
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cs_q  <= CS_IDLE;
         rsp_q <= '0;
      end else begin
         unique case (cs_q)
            CS_IDLE: begin
               if (req_valid && !conflict) begin
                  if (local_hit) begin
                     cs_q  <= CS_DONE;
                     rsp_q <= req_write ? req_wdata : dat_q[r_idx];
                  end else begin
                     cs_q <= CS_BUS;
                  end
               end
            end
            CS_BUS: begin
               if (own_done) begin
                  cs_q  <= CS_DONE;
                  rsp_q <= req_write ? req_wdata : bus_rdata;
               end
            end
            default: cs_q <= CS_IDLE;
         endcase
      end
   end

   // line storage: snoop and own updates never touch the same set in one cycle
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < NSETS; s++) begin
            st_q[s]  <= LN_INV;
            tag_q[s] <= '0;
            dat_q[s] <= '0;
         end
      end else begin
         if (s_hit) begin
            if (bus_cmd == BC_READ)
               st_q[s_idx] <= LN_SHD;
            else if (bus_cmd == BC_RDOWN || bus_cmd == BC_KILL)
               st_q[s_idx] <= LN_INV;
         end
         if (own_wb) begin
            st_q[r_idx] <= LN_INV;
         end
         if (own_done) begin
            tag_q[r_idx] <= r_tag;
            if (req_write) begin
               st_q[r_idx]  <= LN_MOD;
               dat_q[r_idx] <= req_wdata;
            end else begin
               st_q[r_idx]  <= LN_SHD;
               dat_q[r_idx] <= bus_rdata;
            end
         end
         if (hit_go && req_write) begin
            dat_q[r_idx] <= req_wdata;
         end
      end
   end

   assign busy      = (cs_q != CS_IDLE);
   assign rsp_valid = (cs_q == CS_DONE);
   assign rsp_rdata = rsp_q;
endmodule

// File: rtl/snoop_cache_cluster.sv
module snoop_cache_cluster
   import snoopc_pkg::*;
#(
   parameter int NCORES = 3,
   parameter int AW     = 8,
   parameter int DW     = 16,
   parameter int NSETS  = 4,
   parameter int SRCW   = (NCORES > 1) ? $clog2(NCORES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NCORES-1:0]    core_req_valid,
   input  logic [NCORES-1:0]    core_req_write,
   input  logic [NCORES*AW-1:0] core_req_addr,
   input  logic [NCORES*DW-1:0] core_req_wdata,
   output logic [NCORES-1:0]    core_busy,
   output logic [NCORES-1:0]    core_rsp_valid,
   output logic [NCORES*DW-1:0] core_rsp_rdata,
   output logic                 bus_valid,
   output logic [1:0]           bus_cmd,
   output logic [AW-1:0]        bus_addr,
   output logic [SRCW-1:0]      bus_src,
   output logic [AW-1:0]        mem_rd_addr,
   input  logic [DW-1:0]        mem_rd_data,
   output logic                 mem_wr_en,
   output logic [AW-1:0]        mem_wr_addr,
   output logic [DW-1:0]        mem_wr_data
);
   localparam int IW = $clog2(NSETS);

   if (NCORES < 2 || NCORES > 4) begin : g_bad_cores
      $error("NCORES must lie in 2..4");
   end
   if (NSETS < 2 || (NSETS & (NSETS - 1)) != 0) begin : g_bad_sets
      $error("NSETS must be a power of two, at least 2");
   end
   if (AW <= IW) begin : g_bad_aw
      $error("AW must exceed the set index width");
   end
   if (SRCW < $clog2(NCORES)) begin : g_bad_srcw
      $error("SRCW too narrow for NCORES");
   end

   logic [NCORES-1:0] req_w;
   logic [NCORES-1:0] gnt_w;
   logic [NCORES-1:0] flush_w;
   logic [1:0]        cmd_w   [NCORES];
   logic [AW-1:0]     addr_w  [NCORES];
   logic [DW-1:0]     wbd_w   [NCORES];
   logic [DW-1:0]     fld_w   [NCORES];
   logic [DW-1:0]     bus_rdata;
   logic [DW-1:0]     wb_data;
   logic [DW-1:0]     fl_data;

   rr_bus_arbiter #(.N(NCORES)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req_w),
      .gnt   (gnt_w)
   );

   for (genvar g = 0; g < NCORES; g++) begin : g_core
      coh_ctrl #(
         .AW    (AW),
         .DW    (DW),
         .NSETS (NSETS),
         .SRCW  (SRCW),
         .MY_ID (g)
      ) u_ctl (
         .clk          (clk),
         .rst_n        (rst_n),
         .req_valid    (core_req_valid[g]),
         .req_write    (core_req_write[g]),
         .req_addr     (core_req_addr[g*AW +: AW]),
         .req_wdata    (core_req_wdata[g*DW +: DW]),
         .busy         (core_busy[g]),
         .rsp_valid    (core_rsp_valid[g]),
         .rsp_rdata    (core_rsp_rdata[g*DW +: DW]),
         .bus_req      (req_w[g]),
         .bus_gnt      (gnt_w[g]),
         .bus_cmd_o    (cmd_w[g]),
         .bus_addr_o   (addr_w[g]),
         .bus_wdata_o  (wbd_w[g]),
         .bus_valid    (bus_valid),
         .bus_cmd      (bus_cmd),
         .bus_addr     (bus_addr),
         .bus_src      (bus_src),
         .bus_rdata    (bus_rdata),
         .flush_o      (flush_w[g]),
         .flush_data_o (fld_w[g])
      );
   end

   // bus mux: one-hot grant selects the driver; flush data OR-merged
   always_comb begin
      bus_cmd  = '0;
      bus_addr = '0;
      bus_src  = '0;
      wb_data  = '0;
      fl_data  = '0;
      for (int i = 0; i < NCORES; i++) begin
         if (gnt_w[i]) begin
            bus_cmd  = cmd_w[i];
            bus_addr = addr_w[i];
            bus_src  = SRCW'(i);
            wb_data  = wbd_w[i];
         end
         if (flush_w[i]) fl_data = fl_data | fld_w[i];
      end
   end

   assign bus_valid   = |gnt_w;
   assign bus_rdata   = (|flush_w) ? fl_data : mem_rd_data;
   assign mem_rd_addr = bus_addr;
   assign mem_wr_addr = bus_addr;
   assign mem_wr_en   = bus_valid && ((bus_cmd == BC_WBACK) || (|flush_w));
   assign mem_wr_data = (bus_cmd == BC_WBACK) ? wb_data : fl_data;
endmodule

// File: rtl/coh_bus_chk.sv
module coh_bus_chk #(
   parameter int N = 3
) (
   input logic         clk,
   input logic         rst_n,
   input logic [N-1:0] req,
   input logic [N-1:0] gnt,
   input logic [N-1:0] flush_vec,
   input logic         bus_valid,
   input logic [1:0]   bus_cmd,
   input logic         mem_wr_en,
   input logic [N-1:0] rsp_valid,
   input logic [N-1:0] busy
);
   // R10
   gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));

   // R10
   gnt_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~req) == '0);

   // R11
   single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(flush_vec));

   // R4
   kill_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_cmd == 2'd2) |-> (flush_vec == '0 && !mem_wr_en));

   // R1
   idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid |-> !mem_wr_en);

   for (genvar i = 0; i < N; i++) begin : g_core
      // R12
      rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_valid[i] |=> !rsp_valid[i]);
      // R12
      rsp_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_valid[i] |-> busy[i]);
   end
endmodule

bind snoop_cache_cluster coh_bus_chk #(.N(NCORES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req       (req_w),
   .gnt       (gnt_w),
   .flush_vec (flush_w),
   .bus_valid (bus_valid),
   .bus_cmd   (bus_cmd),
   .mem_wr_en (mem_wr_en),
   .rsp_valid (core_rsp_valid),
   .busy      (core_busy)
);

// File: tb/snoop_cache_cluster_bench.sv
module snoop_cache_cluster_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NC   = 3;
   localparam int AW   = 8;
   localparam int DW   = 16;
   localparam int SW   = 2;
   localparam int WDOG = 20000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   logic [NC-1:0]    core_req_valid, core_req_write;
   logic [NC*AW-1:0] core_req_addr;
   logic [NC*DW-1:0] core_req_wdata;
   logic [NC-1:0]    core_busy, core_rsp_valid;
   logic [NC*DW-1:0] core_rsp_rdata;
   logic             bus_valid;
   logic [1:0]       bus_cmd;
   logic [AW-1:0]    bus_addr;
   logic [SW-1:0]    bus_src;
   logic [AW-1:0]    mem_rd_addr, mem_wr_addr;
   logic [DW-1:0]    mem_rd_data, mem_wr_data;
   logic             mem_wr_en;

   logic          rv [NC];
   logic          rw [NC];
   logic [AW-1:0] ra [NC];
   logic [DW-1:0] rd [NC];

   always_comb begin
      for (int i = 0; i < NC; i++) begin
         core_req_valid[i]            = rv[i];
         core_req_write[i]            = rw[i];
         core_req_addr[i*AW +: AW]    = ra[i];
         core_req_wdata[i*DW +: DW]   = rd[i];
      end
   end

   snoop_cache_cluster #(.NCORES(NC), .AW(AW), .DW(DW), .NSETS(4)) u_snoop_cache_cluster (
      .clk(clk), .rst_n(rst_n),
      .core_req_valid(core_req_valid), .core_req_write(core_req_write),
      .core_req_addr(core_req_addr), .core_req_wdata(core_req_wdata),
      .core_busy(core_busy), .core_rsp_valid(core_rsp_valid), .core_rsp_rdata(core_rsp_rdata),
      .bus_valid(bus_valid), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_src(bus_src),
      .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
      .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
   );

   // flat memory model
   logic [DW-1:0] mem [256];
   initial for (int a = 0; a < 256; a++) mem[a] = DW'(16'h100 + a * 3);
   always @(posedge clk) if (mem_wr_en) mem[mem_wr_addr] <= mem_wr_data;
   assign mem_rd_data = mem[mem_rd_addr];

   function automatic logic [DW-1:0] init_word(int a);
      return DW'(16'h100 + a * 3);
   endfunction

   // bus log
   int            log_n = 0;
   int            cyc = 0;
   logic [1:0]    log_cmd  [64];
   logic [AW-1:0] log_addr [64];
   int            log_src  [64];
   int            log_cyc  [64];
   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk) begin
      if (rst_n && bus_valid && log_n < 64) begin
         log_cmd[log_n]  = bus_cmd;
         log_addr[log_n] = bus_addr;
         log_src[log_n]  = int'(bus_src);
         log_cyc[log_n]  = cyc;
         log_n = log_n + 1;
      end
   end

   int tests = 0;
   int fails = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic core_op(input int c, input bit wr, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, output logic [DW-1:0] q);
      @(negedge clk);
      rv[c] = 1'b1; rw[c] = wr; ra[c] = a; rd[c] = d;
      @(negedge clk);
      chk("R12 busy after request", 32'(core_busy[c]), 1);
      while (!core_rsp_valid[c]) @(negedge clk);
      q = core_rsp_rdata[c*DW +: DW];
      rv[c] = 1'b0;
      @(negedge clk);
      chk("R12 pulse ends", 32'(core_rsp_valid[c]), 0);
      chk("R12 busy clears", 32'(core_busy[c]), 0);
   endtask

   task automatic chk_bus(input string tag, input int k, input int cmd, input int addr, input int src);
      chk({tag, " bus cmd"},  32'(log_cmd[k]), 32'(cmd));
      chk({tag, " bus addr"}, 32'(log_addr[k]), 32'(addr));
      chk({tag, " bus src"},  32'(log_src[k]), 32'(src));
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 busy", 32'(core_busy), 0);
      chk("R1 rsp", 32'(core_rsp_valid), 0);
      chk("R1 bus_valid", 32'(bus_valid), 0);
      chk("R1 mem_wr_en", 32'(mem_wr_en), 0);
   endtask

   task automatic t_read_miss_hit();
      logic [DW-1:0] q;
      log_n = 0;
      core_op(0, 0, 8'h10, 0, q);
      chk("R1 first access misses", 32'(log_n), 1);
      chk_bus("R2", 0, 0, 'h10, 0);
      chk("R2 miss data", 32'(q), 32'(init_word('h10)));
      log_n = 0;
      core_op(0, 0, 8'h10, 0, q);
      chk("R2 hit no bus", 32'(log_n), 0);
      chk("R2 hit data", 32'(q), 32'(init_word('h10)));
   endtask

   task automatic t_share_invalidate();
      logic [DW-1:0] q;
      core_op(1, 0, 8'h10, 0, q);
      log_n = 0;
      core_op(1, 1, 8'h10, 16'hBEEF, q);
      chk("R4 one transaction", 32'(log_n), 1);
      chk_bus("R4", 0, 2, 'h10, 1);
      chk("R4 memory untouched", 32'(mem['h10]), 32'(init_word('h10)));
      log_n = 0;
      core_op(0, 0, 8'h10, 0, q);
      chk_bus("R8 sharer misses", 0, 0, 'h10, 0);
      chk("R6 owner supplies", 32'(q), 32'hBEEF);
      chk("R6 memory updated", 32'(mem['h10]), 32'hBEEF);
      log_n = 0;
      core_op(1, 0, 8'h10, 0, q);
      chk("R6 owner keeps shared copy", 32'(log_n), 0);
      chk("R6 owner data", 32'(q), 32'hBEEF);
      log_n = 0;
      core_op(1, 1, 8'h10, 16'hC0DE, q);
      chk_bus("R6 owner now shared", 0, 2, 'h10, 1);
      core_op(0, 0, 8'h10, 0, q);
      chk("R8 newest value", 32'(q), 32'hC0DE);
   endtask

   task automatic t_ownership();
      logic [DW-1:0] q;
      log_n = 0;
      core_op(2, 1, 8'h20, 16'h1234, q);
      chk_bus("R3", 0, 1, 'h20, 2);
      chk("R3 write-back", 32'(mem['h20]), 32'(init_word('h20)));
      log_n = 0;
      core_op(2, 1, 8'h20, 16'h5678, q);
      chk("R5 no bus", 32'(log_n), 0);
      log_n = 0;
      core_op(0, 1, 8'h20, 16'h9999, q);
      chk_bus("R7 rdown", 0, 1, 'h20, 0);
      chk("R7 memory takes owner data", 32'(mem['h20]), 32'h5678);
      log_n = 0;
      core_op(2, 0, 8'h20, 0, q);
      chk_bus("R7 old owner misses", 0, 0, 'h20, 2);
      chk("R7 newest data", 32'(q), 32'h9999);
   endtask

   task automatic t_evict();
      logic [DW-1:0] q;
      core_op(2, 1, 8'h34, 16'hAAAA, q);
      log_n = 0;
      core_op(2, 0, 8'h44, 0, q);
      chk("R9 two transactions", 32'(log_n), 2);
      chk_bus("R9 writeback", 0, 3, 'h34, 2);
      chk_bus("R9 fetch", 1, 0, 'h44, 2);
      chk("R9 memory", 32'(mem['h34]), 32'hAAAA);
      chk("R9 data", 32'(q), 32'(init_word('h44)));
   endtask

   task automatic t_round(input logic [AW-1:0] base);
      logic [DW-1:0] q0, q1, q2;
      int first;
      first = (log_src[log_n - 1] + 1) % NC;
      log_n = 0;
      fork
         core_op(0, 0, base,        0, q0);
         core_op(1, 0, base + 8'd1, 0, q1);
         core_op(2, 0, base + 8'd2, 0, q2);
      join
      chk("R10 three grants", 32'(log_n), 3);
      for (int k = 0; k < 3; k++) begin
         chk("R10 rotation", 32'(log_src[k]), 32'((first + k) % NC));
         chk("R10 back to back", 32'(log_cyc[k] - log_cyc[0]), 32'(k));
      end
      chk("R10 data core0", 32'(q0), 32'(init_word(int'(base))));
      chk("R10 data core2", 32'(q2), 32'(init_word(int'(base) + 2)));
   endtask

   always @(posedge clk) begin
      if (cyc == WDOG) begin
         fails++;
         tests++;
         $display("FAIL watchdog actual=%0d expected<%0d", cyc, WDOG);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] q;
      for (int i = 0; i < NC; i++) begin
         rv[i] = 0; rw[i] = 0; ra[i] = '0; rd[i] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_read_miss_hit();
      t_share_invalidate();
      t_ownership();
      t_evict();
      t_round(8'h90);
      log_n = 0;
      core_op(1, 0, 8'hA7, 0, q);
      t_round(8'hB0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule